// File: doc/BRIEF.md
# Status Byte and Service Request Generator

This block builds an 8-bit status byte for an instrument's host interface. It combines four summaries: the error queue is not empty, the output queue is not empty, an extended event is pending, and a standard event is pending. It takes each event register together with its enable mask, and an event summary is the OR of their bitwise AND. A service request enable register gates which status bits may raise a request. The live OR of the gated bits is the master summary.

A request flag sets on each rising edge of the master summary and drives the `srq` output toward the controller. The host uses a small register port to write and read the enable register. It can also read the status byte in two ways. A status query returns the live master summary in bit 6 and changes nothing. A serial poll returns the latched request flag in bit 6 and then clears that flag.

Top module: `srq_status_unit`

## Requirements
- R1: Bits 7, 1 and 0 of every status query and serial poll result are 0.
- R2: Status bit 2 equals `errQNotEmpty`.
- R3: Status bit 4 equals `outQNotEmpty`.
- R4: Status bit 3 is 1 exactly when `extEvt & extEvtEn` is nonzero.
- R5: Status bit 5 is 1 exactly when `stdEvt & stdEvtEn` is nonzero.
- R6: `masterSummary` is 1, in the same cycle, exactly when the status byte with bit 6 taken as 0, ANDed with the enable register, is nonzero.
- R7: `srq` becomes 1 one cycle after `masterSummary` goes from 0 to 1. It includes the first cycle after reset if the summary is 1 there.
- R8: `srq` becomes 0 one cycle after `masterSummary` is 0, or one cycle after a serial poll. If a summary rising edge and a poll fall in the same cycle, the rising edge wins and `srq` sets.
- R9: A write to address 0 loads `regWdata` into the enable register with bit 6 forced to 0, and a read of address 0 returns it. A status bit whose enable bit is 0 never contributes to `masterSummary` or `srq`.
- R10: A read of address 1 (status query) returns the status byte with `masterSummary` in bit 6 and leaves `srq` unchanged.
- R11: A read of address 2 (serial poll) returns the status byte with the pre-read value of `srq` in bit 6.
- R12: Read data appears on `regRdata` with `regRvalid` high in the cycle after `regRd`. If a read and a write hit the enable register in the same cycle, the read returns the old value. A read of address 3 returns 0, and a write to address 3 changes nothing.
- R13: A synchronous reset (`rst` high at a clock edge) clears the enable register, `srq` and `regRvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stdEvt | input | STD_W | Standard event register contents |
| stdEvtEn | input | STD_W | Standard event enable mask |
| extEvt | input | EXT_W | Extended event register contents |
| extEvtEn | input | EXT_W | Extended event enable mask |
| outQNotEmpty | input | 1 | Output queue holds a response |
| errQNotEmpty | input | 1 | Error queue holds an entry |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 2 | 0 enable, 1 status query, 2 serial poll, 3 unmapped |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid with regRvalid |
| regRvalid | output | 1 | Read data valid, one cycle after regRd |
| masterSummary | output | 1 | Live master summary bit |
| srq | output | 1 | Service request toward the controller |

## Verification
The assertions assume that the read strobe arrives with a stable address in the same cycle. They also assume that `rst` is the only event that breaks the link between the summary history and the request flag. Apart from that they rely only on the port protocol. The stimulus drives all inputs half a cycle away from the active edge and applies any mix of read, write and address. It keeps the event bits sparse so that the summary rises and falls often. Directed sequences add the corner cases: a poll in the same cycle as a rising edge, a query while a request is pending, masked bits and the unmapped address.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int ByteW   = 8;
  localparam int BitErr  = 2;
  localparam int BitExt  = 3;
  localparam int BitMsg  = 4;
  localparam int BitStd  = 5;
  localparam int BitSum  = 6;

  localparam logic [1:0] AddrEnable = 2'd0;
  localparam logic [1:0] AddrStatus = 2'd1;
  localparam logic [1:0] AddrPoll   = 2'd2;

  typedef struct packed {
    logic wrEnable;
    logic rdEnable;
    logic rdStatus;
    logic rdPoll;
    logic rdAny;
  } strobes_t;
endpackage

// File: rtl/srq_ctrl.sv
module srq_ctrl
  import srq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [1:0] regAddr,
  input  logic       mss,
  output strobes_t   strobes,
  output logic       rqsFlag
);
  logic mssPrev;
  logic mssRise;

  // Address decode into strobes
  always_comb begin
    strobes          = '0;
    strobes.rdAny    = regRd;
    strobes.wrEnable = regWr && (regAddr == AddrEnable);
    strobes.rdEnable = regRd && (regAddr == AddrEnable);
    strobes.rdStatus = regRd && (regAddr == AddrStatus);
    strobes.rdPoll   = regRd && (regAddr == AddrPoll);
  end

  assign mssRise = mss && !mssPrev;

  // Request flag: a rising edge wins over a clearing poll in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      mssPrev <= 1'b0;
      rqsFlag <= 1'b0;
    end else begin
      mssPrev <= mss;
      if (mssRise)
        rqsFlag <= 1'b1;
      else if (!mss || strobes.rdPoll)
        rqsFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/srq_datapath.sv
module srq_datapath
  import srq_pkg::*;
#(
  parameter int STD_W = 8,
  parameter int EXT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STD_W-1:0] stdEvt,
  input  logic [STD_W-1:0] stdEvtEn,
  input  logic [EXT_W-1:0] extEvt,
  input  logic [EXT_W-1:0] extEvtEn,
  input  logic             outQNotEmpty,
  input  logic             errQNotEmpty,
  input  logic [ByteW-1:0] regWdata,
  input  strobes_t         strobes,
  input  logic             rqsFlag,
  output logic             mss,
  output logic [ByteW-1:0] regRdata,
  output logic             regRvalid
);
  localparam logic [ByteW-1:0] SumMask = ByteW'(1) << BitSum;

  logic [ByteW-1:0] enableReg;
  logic [ByteW-1:0] statusBase;
  logic [ByteW-1:0] gatedBits;

  // Status byte without bit 6
  always_comb begin
    statusBase         = '0;
    statusBase[BitErr] = errQNotEmpty;
    statusBase[BitExt] = |(extEvt & extEvtEn);
    statusBase[BitMsg] = outQNotEmpty;
    statusBase[BitStd] = |(stdEvt & stdEvtEn);
  end

  for (genvar i = 0; i < ByteW; i++) begin : g_gate
    if (i == BitSum) begin : g_skip
      assign gatedBits[i] = 1'b0;
    end else begin : g_and
      assign gatedBits[i] = statusBase[i] & enableReg[i];
    end
  end

  assign mss = |gatedBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      enableReg <= '0;
    end else if (strobes.wrEnable) begin
      enableReg <= regWdata & ~SumMask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regRvalid <= 1'b0;
      regRdata  <= '0;
    end else begin
      regRvalid <= strobes.rdAny;
      if (strobes.rdEnable)
        regRdata <= enableReg;
      else if (strobes.rdStatus)
        regRdata <= statusBase | (mss ? SumMask : '0);
      else if (strobes.rdPoll)
        regRdata <= statusBase | (rqsFlag ? SumMask : '0);
      else
        regRdata <= '0;
    end
  end
endmodule

// File: rtl/srq_status_unit.sv
module srq_status_unit
  import srq_pkg::*;
#(
  parameter int STD_W = 8,
  parameter int EXT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STD_W-1:0] stdEvt,
  input  logic [STD_W-1:0] stdEvtEn,
  input  logic [EXT_W-1:0] extEvt,
  input  logic [EXT_W-1:0] extEvtEn,
  input  logic             outQNotEmpty,
  input  logic             errQNotEmpty,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic             regRvalid,
  output logic             masterSummary,
  output logic             srq
);
  strobes_t strobes;
  logic     mss;
  logic     rqsFlag;

  srq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .regWr   (regWr),
    .regRd   (regRd),
    .regAddr (regAddr),
    .mss     (mss),
    .strobes (strobes),
    .rqsFlag (rqsFlag)
  );

  srq_datapath #(.STD_W(STD_W), .EXT_W(EXT_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .stdEvt       (stdEvt),
    .stdEvtEn     (stdEvtEn),
    .extEvt       (extEvt),
    .extEvtEn     (extEvtEn),
    .outQNotEmpty (outQNotEmpty),
    .errQNotEmpty (errQNotEmpty),
    .regWdata     (regWdata),
    .strobes      (strobes),
    .rqsFlag      (rqsFlag),
    .mss          (mss),
    .regRdata     (regRdata),
    .regRvalid    (regRvalid)
  );

  assign masterSummary = mss;
  assign srq           = rqsFlag;
endmodule

// File: rtl/srq_checker.sv
module srq_checker (
  input logic       clk,
  input logic       rst,
  input logic       regRd,
  input logic [1:0] regAddr,
  input logic       regRvalid,
  input logic [1:0] rdTop,
  input logic [1:0] rdLow,
  input logic       masterSummary,
  input logic       srq
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (regRvalid && ($past(regAddr) != 2'd0)) |-> (rdTop[1] == 1'b0 && rdLow == 2'b00));

  p_srq_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(masterSummary) |=> srq);

  p_srq_needs_summary_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(srq) |-> $past(masterSummary));

  p_srq_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !masterSummary |=> !srq);

  p_poll_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (regRd && regAddr == 2'd2 && srq) |=> !srq);

  p_enable_bit6_r9: assert property (@(posedge clk) disable iff (rst)
    (regRvalid && $past(regAddr) == 2'd0) |-> (rdTop[0] == 1'b0));

  p_query_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (regRd && regAddr == 2'd1 && srq && masterSummary) |=> srq);

  p_valid_follows_r12: assert property (@(posedge clk) disable iff (rst)
    regRd |=> regRvalid);
endmodule

bind srq_status_unit srq_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .regRd         (regRd),
  .regAddr       (regAddr),
  .regRvalid     (regRvalid),
  .rdTop         (regRdata[7:6]),
  .rdLow         (regRdata[1:0]),
  .masterSummary (masterSummary),
  .srq           (srq)
);

// File: tb/tb_srq_status_unit.sv
module tb_srq_status_unit;
  localparam int STD_W = 8;
  localparam int EXT_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst;
  logic [STD_W-1:0] stdEvt, stdEvtEn;
  logic [EXT_W-1:0] extEvt, extEvtEn;
  logic             outQNotEmpty, errQNotEmpty;
  logic             regWr, regRd;
  logic [1:0]       regAddr;
  logic [7:0]       regWdata, regRdata;
  logic             regRvalid, masterSummary, srq;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mEn;
  logic       mRqs, mPrev;

  srq_status_unit #(.STD_W(STD_W), .EXT_W(EXT_W)) dut (.*);

  function automatic logic [7:0] baseByte();
    logic [7:0] b = 8'h00;
    b[2] = errQNotEmpty;
    b[3] = |(extEvt & extEvtEn);
    b[4] = outQNotEmpty;
    b[5] = |(stdEvt & stdEvtEn);
    return b;
  endfunction

  function automatic logic sumOf(input logic [7:0] b, input logic [7:0] en);
    return |(b & en & 8'hBF);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge with inputs already driven
  task automatic step();
    logic [7:0] b, expData, nEn;
    logic       s, expValid, nRqs;
    string      tag;
    #1;
    b = baseByte();
    s = sumOf(b, mEn);
    check("R6 summary", {7'd0, masterSummary}, {7'd0, s});
    expValid = regRd;
    case (regAddr)
      2'd0:    begin expData = mEn;                  tag = "R9 R13 enable readback"; end
      2'd1:    begin expData = b | {1'b0, s, 6'd0};    tag = "R1 R2 R3 R4 R5 R10 status query"; end
      2'd2:    begin expData = b | {1'b0, mRqs, 6'd0}; tag = "R1 R11 serial poll"; end
      default: begin expData = 8'h00;                tag = "R12 unmapped read"; end
    endcase
    if (s && !mPrev)                       nRqs = 1'b1;
    else if (!s || (regRd && regAddr == 2'd2)) nRqs = 1'b0;
    else                                   nRqs = mRqs;
    nEn = (regWr && regAddr == 2'd0) ? (regWdata & 8'hBF) : mEn;
    @(posedge clk);
    #1;
    mRqs = nRqs; mPrev = s; mEn = nEn;
    check("R7 R8 srq", {7'd0, srq}, {7'd0, mRqs});
    check("R12 valid", {7'd0, regRvalid}, {7'd0, expValid});
    if (expValid) check(tag, regRdata, expData);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; regRd = 1'b0; regWr = 1'b0;
    @(posedge clk);
    #1;
    mEn = 8'h00; mRqs = 1'b0; mPrev = 1'b0;
    check("R13 srq after reset", {7'd0, srq}, 8'h00);
    check("R13 valid after reset", {7'd0, regRvalid}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle();
    regWr = 1'b0; regRd = 1'b0; regAddr = 2'd3; regWdata = 8'h00;
  endtask

  task automatic wrEn(input logic [7:0] v);
    regWr = 1'b1; regRd = 1'b0; regAddr = 2'd0; regWdata = v;
    step();
    idle();
  endtask

  task automatic rdAt(input logic [1:0] a);
    regWr = 1'b0; regRd = 1'b1; regAddr = a;
    step();
    idle();
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL R13 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    stdEvt = '0; stdEvtEn = '0; extEvt = '0; extEvtEn = '0;
    outQNotEmpty = 1'b0; errQNotEmpty = 1'b0;
    idle();
    mEn = 8'h00; mRqs = 1'b0; mPrev = 1'b0;
    @(negedge clk);
    doReset();

    // R9: bit 6 forced to 0, other bits read back
    wrEn(8'hFF);
    rdAt(2'd0);
    // Raise a request, then reset it away (R13)
    errQNotEmpty = 1'b1; step(); step();
    doReset();
    rdAt(2'd0);
    // R9: masked bits cannot request
    wrEn(8'h04);
    errQNotEmpty = 1'b0; outQNotEmpty = 1'b1; stdEvt = 8'h01; stdEvtEn = 8'h01;
    step(); step();
    rdAt(2'd1);
    // R8: rising edge together with a poll sets the flag
    errQNotEmpty = 1'b1; regRd = 1'b1; regAddr = 2'd2; step(); idle();
    rdAt(2'd1);           // R10: query leaves srq set
    rdAt(2'd2);           // R11: poll returns 1 then clears
    step(); step();       // no new edge, stays clear
    errQNotEmpty = 1'b0; step();
    errQNotEmpty = 1'b1; step();
    errQNotEmpty = 1'b0; step(); // R8: fall clears
    // R12: unmapped write ignored, unmapped read returns 0
    regWr = 1'b1; regAddr = 2'd3; regWdata = 8'hFF; step(); idle();
    rdAt(2'd0);
    rdAt(2'd3);
    // R12: read and write of enable in one cycle returns the old value
    regWr = 1'b1; regRd = 1'b1; regAddr = 2'd0; regWdata = 8'h3C; step(); idle();
    rdAt(2'd0);
    // R4: extended summary
    extEvt = 16'h8000; extEvtEn = 16'h8000; rdAt(2'd1);
    extEvtEn = 16'h7FFF; rdAt(2'd1);

    for (int i = 0; i < 4000; i++) begin
      stdEvt       = STD_W'($urandom & $urandom & $urandom);
      stdEvtEn     = STD_W'($urandom);
      extEvt       = EXT_W'($urandom & $urandom & $urandom & $urandom);
      extEvtEn     = EXT_W'($urandom);
      outQNotEmpty = ($urandom % 4) == 0;
      errQNotEmpty = ($urandom % 5) == 0;
      regRd        = ($urandom % 10) < 3;
      regWr        = ($urandom % 10) == 0;
      regAddr      = 2'($urandom);
      regWdata     = 8'($urandom);
      if (($urandom % 200) == 0) doReset();
      else step();
    end
    idle();
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule